// File: doc/BRIEF.md
# Second-Chance Frame Victim Selector

This block picks which physical frame to evict when memory is full. It keeps one "recently used" flag per frame and treats the frames as a ring, with a persistent pointer (the hand) into that ring. Whenever the surrounding logic touches a frame, it pulses the mark input with that frame's index, and the frame's flag is set.

When a victim is wanted, the requester raises the request input while the block is idle. The block then steps around the ring, one frame per clock, starting at the hand. A frame whose flag is set gets its flag dropped and a second chance. The first frame found with its flag already dropped becomes the victim. The block returns that frame's index with a one-cycle valid pulse and leaves the hand on the next frame in the ring. The flags and the hand persist between requests, so recent use steers later choices.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, `busy` and `victim_vld` are low, every frame flag is clear and the hand is at frame 0, so the first request returns frame 0.
- R2: A cycle with `mark_vld` high sets the flag of frame `mark_idx`, and that frame is passed over by the next sweep that reaches it.
- R3: A sweep begins at the hand and visits frames in increasing index order, wrapping from NFRAMES-1 to 0.
- R4: The victim is the first visited frame whose flag is clear. `victim_vld` is high for one cycle with the index on `victim_idx`, and it arrives 1 + k clock edges after the accepting edge, where k is the number of flagged frames passed.
- R5: Every flagged frame passed by a sweep has its flag cleared.
- R6: After a victim is reported, the hand points to the frame that follows the victim, with wrap.
- R7: If all flags are set, the sweep goes once around the whole ring, clears every flag and returns the frame it started at, NFRAMES + 1 edges after acceptance.
- R8: If a mark hits the frame that the sweep is clearing in the same cycle, the mark wins and the flag stays set.
- R9: A request is accepted only while `busy` is low. `busy` is high from the edge after acceptance until the edge on which the victim is presented, and is low while `victim_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mark_vld | input | 1 | Frame-touched strobe |
| mark_idx | input | IDX_W | Index of the touched frame |
| req | input | 1 | Victim request, taken while `busy` is low |
| busy | output | 1 | Sweep in progress |
| victim_vld | output | 1 | One-cycle pulse: `victim_idx` holds the victim |
| victim_idx | output | IDX_W | Chosen frame index |

## Verification
The bench measures the latency of each victim in clock edges, and this shows how many frames the sweep passed. A design that failed to clear passed flags would skip those frames again on the next lap. A hand that did not move past the victim would return the same frame twice in a row. The all-flags-set case checks that the sweep wraps fully and that the ring comes back empty; a design that stopped early, or that never ended, would give the wrong index or hang. The bench drives a mark into the exact cycle in which the sweep clears that frame. A design that let the clear win would pick that frame on the next lap instead of skipping it.

// File: rtl/clkrep_pkg.sv
package clkrep_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_st_e;
endpackage

// File: rtl/clkrep_refbits.sv
// Per-frame recently-used flags; a set request outranks a clear request.
module clkrep_refbits #(
  parameter int NFRAMES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [NFRAMES-1:0] flags_o
);
  for (genvar g = 0; g < NFRAMES; g++) begin : g_flag
    logic set_hit, clr_hit, flag_nxt, flag_q;

    always_comb begin
      set_hit  = set_en && (set_idx == IDX_W'(g));
      clr_hit  = clr_en && (clr_idx == IDX_W'(g));
      flag_nxt = set_hit ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  flag_q <= 1'b0;
      else if (set_hit || clr_hit) flag_q <= flag_nxt;
    end

    assign flags_o[g] = flag_q;
  end
endmodule

// File: rtl/clkrep_hand.sv
// Ring pointer; a power-of-two ring wraps on its own, any other size compares.
module clkrep_hand #(
  parameter int NFRAMES = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [IDX_W-1:0] hand_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NFRAMES - 1);
  localparam bit               POW2 = ((1 << IDX_W) == NFRAMES);

  logic [IDX_W-1:0] hand_q, hand_nxt;

  if (POW2) begin : g_pow2
    always_comb hand_nxt = hand_q + 1'b1;
  end else begin : g_cmp
    always_comb hand_nxt = (hand_q == LAST) ? '0 : hand_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hand_q <= '0;
    else if (adv_i) hand_q <= hand_nxt;
  end

  assign hand_o = hand_q;
endmodule

// File: rtl/clkrep_sweep.sv
// Sweep control: one ring position examined per cycle while sweeping.
module clkrep_sweep #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             cur_flag_i,
  input  logic [IDX_W-1:0] hand_i,
  output logic             clr_en_o,
  output logic             adv_o,
  output logic             busy_o,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  import clkrep_pkg::*;

  sweep_st_e        st_q, st_nxt;
  logic             vld_q, vld_nxt;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             idx_en;

  always_comb begin
    st_nxt   = st_q;
    clr_en_o = 1'b0;
    adv_o    = 1'b0;
    vld_nxt  = 1'b0;
    idx_en   = 1'b0;
    idx_nxt  = hand_i;
    case (st_q)
      ST_IDLE: begin
        if (req_i) st_nxt = ST_SWEEP;
      end
      ST_SWEEP: begin
        adv_o = 1'b1;
        if (cur_flag_i) begin
          clr_en_o = 1'b1;
        end else begin
          vld_nxt = 1'b1;
          idx_en  = 1'b1;
          st_nxt  = ST_IDLE;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      vld_q <= vld_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_nxt;
  end

  assign busy_o = (st_q == ST_SWEEP);
  assign vld_o  = vld_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NFRAMES = 16,
  parameter int IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark_vld,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic             req,
  output logic             busy,
  output logic             victim_vld,
  output logic [IDX_W-1:0] victim_idx
);
  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic [NFRAMES-1:0] flags;
  logic [IDX_W-1:0]   hand;
  logic               cur_flag, clr_en, adv;

  // Reset asserts at once and leaves only after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign cur_flag = flags[hand];

  clkrep_refbits #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_en  (mark_vld),
    .set_idx (mark_idx),
    .clr_en  (clr_en),
    .clr_idx (hand),
    .flags_o (flags)
  );

  clkrep_hand #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_hand (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .adv_i  (adv),
    .hand_o (hand)
  );

  clkrep_sweep #(.IDX_W(IDX_W)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_i      (req),
    .cur_flag_i (cur_flag),
    .hand_i     (hand),
    .clr_en_o   (clr_en),
    .adv_o      (adv),
    .busy_o     (busy),
    .vld_o      (victim_vld),
    .idx_o      (victim_idx)
  );
endmodule

// File: rtl/clkrep_chk.sv
module clkrep_chk #(
  parameter int NFRAMES = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req,
  input logic               busy,
  input logic               victim_vld,
  input logic [IDX_W-1:0]   victim_idx,
  input logic               mark_vld,
  input logic [IDX_W-1:0]   mark_idx,
  input logic [IDX_W-1:0]   hand,
  input logic [NFRAMES-1:0] flags
);
  logic [IDX_W-1:0] after_victim;
  assign after_victim = (victim_idx == IDX_W'(NFRAMES - 1)) ? '0 : victim_idx + 1'b1;

  p_mark_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mark_vld |=> flags[$past(mark_idx)]);

  p_victim_at_hand_r4: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld |-> (victim_idx == $past(hand)));

  p_pass_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && flags[hand] && !(mark_vld && mark_idx == hand)) |=> !flags[$past(hand)]);

  p_hand_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld |-> (hand == after_victim));

  p_mark_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mark_vld && mark_idx == hand) |=> flags[$past(hand)]);

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> busy);

  p_vld_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld |-> !busy);

  p_end_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> victim_vld);
endmodule

bind clock_victim_sel clkrep_chk #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req        (req),
  .busy       (busy),
  .victim_vld (victim_vld),
  .victim_idx (victim_idx),
  .mark_vld   (mark_vld),
  .mark_idx   (mark_idx),
  .hand       (hand),
  .flags      (flags)
);

// File: tb/tb_clock_victim_sel.sv
`timescale 1ns/1ps
module tb_clock_victim_sel;
  localparam int N  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mark_vld;
  logic [IW-1:0] mark_idx;
  logic          req;
  logic          busy, victim_vld;
  logic [IW-1:0] victim_idx;

  int tests  = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  clock_victim_sel #(.NFRAMES(N)) dut (
    .clk(clk), .rst_n(rst_n), .mark_vld(mark_vld), .mark_idx(mark_idx),
    .req(req), .busy(busy), .victim_vld(victim_vld), .victim_idx(victim_idx)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(string req_tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req_tag, act, exp);
    end
  endtask

  task automatic mark(int f);
    @(negedge clk);
    mark_vld = 1'b1;
    mark_idx = IW'(f);
    @(posedge clk);
    @(negedge clk);
    mark_vld = 1'b0;
  endtask

  // Issues one request. mark_at>0 drives a mark of frame mark_f so that it
  // is seen on the mark_at-th edge after acceptance.
  task automatic request(output int idx, output int lat, input int mark_at, input int mark_f);
    @(negedge clk);
    req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    chk("R9 busy after accept", int'(busy), 1);
    lat = 0;
    while (!victim_vld && lat < 200) begin
      if (mark_at > 0 && lat + 1 == mark_at) begin
        mark_vld = 1'b1;
        mark_idx = IW'(mark_f);
      end
      @(posedge clk);
      @(negedge clk);
      mark_vld = 1'b0;
      lat++;
    end
    chk("R9 busy low with victim", int'(busy), 0);
    idx = int'(victim_idx);
  endtask

  task automatic t_reset_r1();
    int idx, lat;
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 vld at reset", int'(victim_vld), 0);
    request(idx, lat, 0, 0);
    chk("R1 first victim", idx, 0);
    chk("R1 first latency", lat, 1);
  endtask

  task automatic t_skip_clear();
    int idx, lat;
    for (int f = 1; f <= 3; f++) mark(f);
    request(idx, lat, 0, 0);
    chk("R2 marked skipped idx", idx, 4);
    chk("R4 latency over 3 set", lat, 4);
    for (int f = 5; f < N; f++) mark(f);
    request(idx, lat, 0, 0);
    chk("R3 wrap to frame 0", idx, 0);
    chk("R3 wrap latency", lat, 12);
    request(idx, lat, 0, 0);
    chk("R5 passed frame 1 cleared", idx, 1);
    chk("R5 latency", lat, 1);
    request(idx, lat, 0, 0);
    chk("R6 hand after victim", idx, 2);
  endtask

  task automatic t_all_set_r7();
    int idx, lat;
    for (int f = 0; f < N; f++) mark(f);
    request(idx, lat, 0, 0);
    chk("R7 all set picks start", idx, 3);
    chk("R7 full lap latency", lat, N + 1);
    request(idx, lat, 0, 0);
    chk("R7 ring empty after lap", idx, 4);
    chk("R7 latency after lap", lat, 1);
  endtask

  task automatic t_mark_wins_r8();
    int idx, lat;
    mark(5); mark(6); mark(7);
    request(idx, lat, 2, 6);
    chk("R8 victim after passes", idx, 8);
    chk("R8 latency", lat, 4);
    for (int k = 0; k < 13; k++) begin
      request(idx, lat, 0, 0);
      chk("R6 stepping victims", idx, (9 + k) % N);
    end
    request(idx, lat, 0, 0);
    chk("R8 frame 6 kept its flag", idx, 7);
    chk("R8 one pass latency", lat, 2);
  endtask

  initial begin
    rst_n    = 1'b0;
    mark_vld = 1'b0;
    mark_idx = '0;
    req      = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_r1();
    t_skip_clear();
    t_all_set_r7();
    t_mark_wins_r8();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule